// File: doc/BRIEF.md
# Vector Loop Element Sequencer

This block sits on the issue side of a core. It expands one loop-prefixed instruction into a run of element operations. The decoder presents an instruction and holds it: a prefix flag, the suffix class, the suffix base register numbers, a mode bit and the current vector length. For each element, the sequencer adds the current element offset to every base register number. It puts out the resulting register indices with a valid strobe for the execution side. When the instruction is finished, it raises an advance request so the decoder moves on.

The sequencer has two modes. In horizontal-first mode it walks the offset from zero to the last element before it releases the instruction. In vertical-first mode each prefixed instruction issues one element at the current offset and is released at once. The offset is shared by the instructions that follow and moves only when a separate step command arrives. A prefixed suffix whose class cannot be looped raises an illegal-instruction trap instead of issuing. An unprefixed instruction issues once, with its register numbers unchanged.

Top module: `vec_elem_seq`

## Requirements
- R1: After reset the element offset is 0, and elem_valid_o, trap_o, insn_adv_o and loop_end_o are all low while no instruction is presented.
- R2: A presented prefixed instruction whose insn_class_i is 5, 6 or 7 raises trap_o and insn_adv_o in that cycle, keeps elem_valid_o low and leaves the offset unchanged. Classes 0 to 4 never trap. These are immediate load/store, indexed load/store, arithmetic/logical, condition-register op and conditional branch.
- R3: For a prefixed loopable instruction, operand k of elem_regs_o (bits [7k+6:7k]) equals the zero-extended 5-bit base in base_regs_i bits [5k+4:5k] plus the current offset.
- R4: In horizontal-first mode (insn_vf_i = 0), offsets 0, 1, ... VL-1 are issued in order. insn_adv_o is high only on the issuing cycle of the last element, and the offset reads 0 from the next cycle.
- R5: In vertical-first mode (insn_vf_i = 1), a prefixed instruction issues one element and raises insn_adv_o in that same cycle, and the offset does not change.
- R6: In vertical-first mode, a following prefixed instruction issues at the same offset as the previous one.
- R7: A step command (step_i high with insn_valid_i low) advances the offset by one. At offset VL-1 it wraps the offset to 0 instead, and loop_end_o is high for exactly the next cycle.
- R8: step_i has no effect on the offset while insn_valid_i is high.
- R9: While elem_ready_i is low, elem_valid_o and insn_adv_o stay low for issuable instructions and the offset holds. An element issues only on a cycle with both valid and ready high.
- R10: An unprefixed instruction of any class issues one element with the base register numbers unchanged, raises insn_adv_o with it, and leaves the offset unchanged.
- R11: A vector length of 0 is treated as 1, and a length above 64 is treated as 64.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| insn_valid_i | input | 1 | A decoded instruction is presented (held until advance) |
| insn_prefixed_i | input | 1 | Instruction carries a loop prefix |
| insn_class_i | input | 3 | Suffix class, 0..4 loopable, 5..7 unvectorizable |
| insn_vf_i | input | 1 | Mode: 1 vertical-first, 0 horizontal-first |
| vl_i | input | 7 | Current vector length |
| base_regs_i | input | 15 | Three 5-bit suffix register numbers |
| step_i | input | 1 | Explicit offset step command |
| elem_ready_i | input | 1 | Downstream can accept an element |
| elem_valid_o | output | 1 | Element operation issued this cycle |
| elem_regs_o | output | 21 | Three 7-bit element register indices |
| elem_off_o | output | 6 | Current element offset |
| insn_adv_o | output | 1 | Request to advance to the next instruction |
| trap_o | output | 1 | Illegal-instruction trap |
| loop_end_o | output | 1 | One-cycle flag after a wrapping step |

## Verification
On every cycle, the assertions check several cycle-to-cycle relations. An offset that fires on the last horizontal element returns to zero. The offset holds during stalls, vertical-first issues, unprefixed issues and steps that arrive alongside an instruction. A wrapping step produces the end-of-loop flag, and that flag only appears with a zero offset. A trap never issues an element. The exact order of the offset values across a whole horizontal loop, the treatment of out-of-range lengths, and the register arithmetic can only be shown by the bench's scenarios. The same holds for the offset being shared between successive vertical-first instructions.

// File: rtl/vec_seq_pkg.sv
package vec_seq_pkg;

  typedef enum logic [1:0] {
    ACT_IDLE   = 2'd0,
    ACT_SCALAR = 2'd1,
    ACT_LOOP   = 2'd2,
    ACT_TRAP   = 2'd3
  } act_e;

  localparam int CLS_W = 3;
  // classes 0..4 loopable: ld/st imm, ld/st idx, alu, cr op, cond branch
  localparam logic [CLS_W-1:0] CLS_LAST_LOOPABLE = 3'd4;

  function automatic logic cls_loopable(logic [CLS_W-1:0] cls);
    return cls <= CLS_LAST_LOOPABLE;
  endfunction

endpackage

// File: rtl/vec_seq_classify.sv
module vec_seq_classify
  import vec_seq_pkg::*;
(
  input  logic             valid_i,
  input  logic             prefixed_i,
  input  logic [CLS_W-1:0] cls_i,
  output act_e             act_o
);

  always_comb begin
    if (!valid_i)                act_o = ACT_IDLE;
    else if (!prefixed_i)        act_o = ACT_SCALAR;
    else if (cls_loopable(cls_i)) act_o = ACT_LOOP;
    else                         act_o = ACT_TRAP;
  end

endmodule

// File: rtl/vec_seq_offset.sv
module vec_seq_offset #(
  parameter int MAX_VL = 64,
  parameter int VL_W   = 7,
  parameter int OFF_W  = $clog2(MAX_VL)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [VL_W-1:0]  vl_i,
  input  logic             fire_hf_i,
  input  logic             step_i,
  output logic [OFF_W-1:0] off_o,
  output logic             last_o,
  output logic             loop_end_o
);

  localparam logic [VL_W-1:0] MAX_VL_V  = VL_W'(MAX_VL);
  localparam logic [VL_W-1:0] MAX_IDX_V = VL_W'(MAX_VL - 1);

  logic [OFF_W-1:0] off_q;
  logic [VL_W-1:0]  last_idx;
  logic             loop_end_q;

  // clamp length into 1..MAX_VL
  always_comb begin
    if (vl_i == '0)          last_idx = '0;
    else if (vl_i > MAX_VL_V) last_idx = MAX_IDX_V;
    else                     last_idx = vl_i - 1'b1;
  end

  assign last_o = VL_W'(off_q) >= last_idx;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      off_q      <= '0;
      loop_end_q <= 1'b0;
    end else begin
      loop_end_q <= step_i && last_o;
      if (fire_hf_i || step_i) off_q <= last_o ? '0 : off_q + 1'b1;
    end
  end

  assign off_o      = off_q;
  assign loop_end_o = loop_end_q;

  a_r4_hf_wrap: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fire_hf_i && last_o) |=> (off_q == '0));
  a_r7_wrap_flag: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (step_i && last_o) |=> loop_end_o);
  a_r7_flag_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    loop_end_o |-> (off_q == '0));
  a_r7_no_spurious_flag: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !step_i |=> !loop_end_o);

endmodule

// File: rtl/vec_seq_regmap.sv
module vec_seq_regmap #(
  parameter int NUM_OPS = 3,
  parameter int SRC_W   = 5,
  parameter int DST_W   = 7,
  parameter int OFF_W   = 6
) (
  input  logic [NUM_OPS*SRC_W-1:0] base_i,
  input  logic [OFF_W-1:0]         off_i,
  input  logic                     add_i,
  output logic [NUM_OPS*DST_W-1:0] regs_o
);

  logic [DST_W-1:0] delta;
  assign delta = add_i ? DST_W'(off_i) : '0;

  for (genvar k = 0; k < NUM_OPS; k++) begin : g_op
    assign regs_o[k*DST_W +: DST_W] = DST_W'(base_i[k*SRC_W +: SRC_W]) + delta;
  end

endmodule

// File: rtl/vec_elem_seq.sv
module vec_elem_seq
  import vec_seq_pkg::*;
#(
  parameter int NUM_OPS   = 3,
  parameter int SRC_REG_W = 5,
  parameter int DST_REG_W = 7,
  parameter int MAX_VL    = 64,
  parameter int VL_W      = 7,
  localparam int OFF_W    = $clog2(MAX_VL)
) (
  input  logic                         clk_i,
  input  logic                         rst_ni,
  input  logic                         insn_valid_i,
  input  logic                         insn_prefixed_i,
  input  logic [2:0]                   insn_class_i,
  input  logic                         insn_vf_i,
  input  logic [VL_W-1:0]              vl_i,
  input  logic [NUM_OPS*SRC_REG_W-1:0] base_regs_i,
  input  logic                         step_i,
  input  logic                         elem_ready_i,
  output logic                         elem_valid_o,
  output logic [NUM_OPS*DST_REG_W-1:0] elem_regs_o,
  output logic [OFF_W-1:0]             elem_off_o,
  output logic                         insn_adv_o,
  output logic                         trap_o,
  output logic                         loop_end_o
);

  act_e             act;
  logic             fire, fire_hf, step_eff, last;
  logic [OFF_W-1:0] off;

  vec_seq_classify u_cls (
    .valid_i    (insn_valid_i),
    .prefixed_i (insn_prefixed_i),
    .cls_i      (insn_class_i),
    .act_o      (act)
  );

  assign fire     = elem_ready_i && (act == ACT_SCALAR || act == ACT_LOOP);
  assign fire_hf  = fire && (act == ACT_LOOP) && !insn_vf_i;
  // a step is its own instruction; ignore it while another is presented
  assign step_eff = step_i && !insn_valid_i;

  vec_seq_offset #(
    .MAX_VL (MAX_VL),
    .VL_W   (VL_W),
    .OFF_W  (OFF_W)
  ) u_off (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .vl_i       (vl_i),
    .fire_hf_i  (fire_hf),
    .step_i     (step_eff),
    .off_o      (off),
    .last_o     (last),
    .loop_end_o (loop_end_o)
  );

  vec_seq_regmap #(
    .NUM_OPS (NUM_OPS),
    .SRC_W   (SRC_REG_W),
    .DST_W   (DST_REG_W),
    .OFF_W   (OFF_W)
  ) u_map (
    .base_i (base_regs_i),
    .off_i  (off),
    .add_i  (act == ACT_LOOP),
    .regs_o (elem_regs_o)
  );

  assign elem_valid_o = fire;
  assign trap_o       = (act == ACT_TRAP);
  assign insn_adv_o   = trap_o ||
                        (fire && (act == ACT_SCALAR || insn_vf_i || last));
  assign elem_off_o   = off;

  a_r2_trap_no_issue: assert property (@(posedge clk_i) disable iff (!rst_ni)
    trap_o |-> (!elem_valid_o && insn_adv_o));
  a_r2_trap_keeps_off: assert property (@(posedge clk_i) disable iff (!rst_ni)
    trap_o |=> $stable(elem_off_o));
  a_r5_vf_holds_off: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (elem_valid_o && insn_prefixed_i && insn_vf_i) |=> $stable(elem_off_o));
  a_r8_step_masked: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (step_i && insn_valid_i && !elem_valid_o) |=> $stable(elem_off_o));
  a_r9_stall_holds: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (insn_valid_i && !elem_ready_i) |=> $stable(elem_off_o));
  a_r9_no_adv_stalled: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!elem_ready_i && !trap_o) |-> !insn_adv_o);
  a_r10_scalar_holds: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (elem_valid_o && !insn_prefixed_i) |=> $stable(elem_off_o));

endmodule

// File: tb/vec_elem_seq_test.sv
module vec_elem_seq_test;

  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        insn_valid_i = 1'b0;
  logic        insn_prefixed_i = 1'b0;
  logic [2:0]  insn_class_i = '0;
  logic        insn_vf_i = 1'b0;
  logic [6:0]  vl_i = 7'd1;
  logic [14:0] base_regs_i = '0;
  logic        step_i = 1'b0;
  logic        elem_ready_i = 1'b0;
  logic        elem_valid_o;
  logic [20:0] elem_regs_o;
  logic [5:0]  elem_off_o;
  logic        insn_adv_o;
  logic        trap_o;
  logic        loop_end_o;

  int n_chk = 0;
  int n_err = 0;
  bit finished = 0;

  always #10 clk_i = ~clk_i;

  vec_elem_seq uut (
    .clk_i(clk_i), .rst_ni(rst_ni), .insn_valid_i(insn_valid_i),
    .insn_prefixed_i(insn_prefixed_i), .insn_class_i(insn_class_i),
    .insn_vf_i(insn_vf_i), .vl_i(vl_i), .base_regs_i(base_regs_i),
    .step_i(step_i), .elem_ready_i(elem_ready_i), .elem_valid_o(elem_valid_o),
    .elem_regs_o(elem_regs_o), .elem_off_o(elem_off_o), .insn_adv_o(insn_adv_o),
    .trap_o(trap_o), .loop_end_o(loop_end_o)
  );

  task automatic chk(string req, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_err++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int exp_regs(logic [14:0] b, int off);
    int r = 0;
    for (int k = 0; k < 3; k++) r |= ((int'((b >> (5*k)) & 15'h1f) + off) & 7'h7f) << (7*k);
    return r;
  endfunction

  task automatic cyc();
    @(posedge clk_i);
    @(negedge clk_i);
  endtask

  task automatic summary();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_err);
  endtask

  task automatic present(bit pf, logic [2:0] cls, bit vf, logic [14:0] b);
    insn_valid_i = 1'b1; insn_prefixed_i = pf; insn_class_i = cls;
    insn_vf_i = vf; base_regs_i = b;
  endtask

  int vls[8] = '{1, 2, 3, 5, 8, 64, 0, 100};

  initial begin
    int voff;
    @(negedge clk_i);
    @(negedge clk_i);
    rst_ni = 1'b1;
    #2;
    chk("R1 off", elem_off_o, 0);
    chk("R1 valid", elem_valid_o, 0);
    chk("R1 trap", trap_o, 0);
    chk("R1 adv", insn_adv_o, 0);
    chk("R1 loop_end", loop_end_o, 0);
    @(negedge clk_i);

    // horizontal-first sweep with periodic stalls
    foreach (vls[i]) begin
      int eff, exp_off, cnt;
      bit done;
      eff = (vls[i] == 0) ? 1 : (vls[i] > 64 ? 64 : vls[i]);
      vl_i = 7'(vls[i]);
      present(1'b1, 3'd2, 1'b0, {5'd31, 5'd17, 5'd3});
      exp_off = 0; cnt = 0; done = 0;
      while (!done && cnt < 200) begin
        bit rdy;
        rdy = (cnt % 3) != 2;
        elem_ready_i = rdy;
        #2;
        chk("R9 valid follows ready", elem_valid_o, int'(rdy));
        chk("R4 offset order", elem_off_o, exp_off);
        chk("R3 regs", elem_regs_o, exp_regs(base_regs_i, exp_off));
        chk("R4/R11 adv on last", insn_adv_o, int'(rdy && exp_off == eff - 1));
        @(posedge clk_i);
        if (rdy) begin
          if (exp_off == eff - 1) begin done = 1; exp_off = 0; end
          else exp_off++;
        end
        @(negedge clk_i);
        cnt++;
      end
      insn_valid_i = 1'b0;
      #2;
      chk("R4 offset back to 0", elem_off_o, 0);
      @(negedge clk_i);
    end

    // vertical-first
    vl_i = 7'd4; voff = 0;
    present(1'b1, 3'd0, 1'b1, {5'd1, 5'd2, 5'd3});
    elem_ready_i = 1'b1;
    #2;
    chk("R5 vf valid", elem_valid_o, 1);
    chk("R5 vf adv", insn_adv_o, 1);
    chk("R5 vf regs", elem_regs_o, exp_regs(base_regs_i, voff));
    cyc();
    chk("R5 vf offset held", elem_off_o, voff);
    present(1'b1, 3'd3, 1'b1, {5'd10, 5'd20, 5'd30});
    elem_ready_i = 1'b0;
    #2;
    chk("R9 vf stall valid", elem_valid_o, 0);
    chk("R9 vf stall adv", insn_adv_o, 0);
    elem_ready_i = 1'b1;
    #2;
    chk("R6 shared offset", elem_regs_o, exp_regs(base_regs_i, voff));
    chk("R6 adv", insn_adv_o, 1);
    cyc();

    insn_valid_i = 1'b0; step_i = 1'b1;
    cyc();
    step_i = 1'b0; voff = 1;
    chk("R7 step advances", elem_off_o, voff);
    chk("R7 no flag mid-loop", loop_end_o, 0);
    present(1'b1, 3'd4, 1'b1, {5'd5, 5'd6, 5'd7});
    elem_ready_i = 1'b0;
    step_i = 1'b1;
    cyc();
    step_i = 1'b0;
    chk("R8 step ignored", elem_off_o, voff);
    elem_ready_i = 1'b1;
    #2;
    chk("R6 regs at stepped offset", elem_regs_o, exp_regs(base_regs_i, voff));
    cyc();

    // traps
    for (int c = 5; c < 8; c++) begin
      present(1'b1, 3'(c), 1'b1, {5'd9, 5'd9, 5'd9});
      #2;
      chk("R2 trap", trap_o, 1);
      chk("R2 trap adv", insn_adv_o, 1);
      chk("R2 trap no elem", elem_valid_o, 0);
      cyc();
      chk("R2 offset kept", elem_off_o, voff);
    end
    elem_ready_i = 1'b0;
    for (int c = 0; c < 5; c++) begin
      present(1'b1, 3'(c), 1'b0, '0);
      #2;
      chk("R2 loopable no trap", trap_o, 0);
    end
    cyc();

    // unprefixed
    elem_ready_i = 1'b1;
    present(1'b0, 3'd7, 1'b0, {5'd12, 5'd13, 5'd14});
    #2;
    chk("R10 scalar valid", elem_valid_o, 1);
    chk("R10 scalar regs", elem_regs_o, exp_regs(base_regs_i, 0));
    chk("R10 scalar no trap", trap_o, 0);
    chk("R10 scalar adv", insn_adv_o, 1);
    cyc();
    chk("R10 offset kept", elem_off_o, voff);

    // step to wrap
    insn_valid_i = 1'b0; elem_ready_i = 1'b0;
    for (int s = 0; s < 3; s++) begin
      step_i = 1'b1;
      cyc();
      voff = (voff == 3) ? 0 : voff + 1;
      chk("R7 step offset", elem_off_o, voff);
      chk("R7 loop_end", loop_end_o, int'(voff == 0));
    end
    step_i = 1'b0;
    cyc();
    chk("R7 loop_end one cycle", loop_end_o, 0);
    chk("R7 wrapped offset", elem_off_o, 0);

    finished = 1;
    summary();
    $finish;
  end

  initial begin
    #(20 * 150000);
    if (!finished) begin
      n_err++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      summary();
      $finish;
    end
  end

endmodule